// File: doc/BRIEF.md
# Saturating Calibration Trim Register with Nonvolatile Store Sequencer

This block keeps a 7-bit calibration code that drives a current-output DAC. The DAC output current is proportional to the code, one step per count out of 128. After power-up the block reads the stored code from a simple nonvolatile memory port and loads it into the trim register. It then accepts single-step increment and decrement strobes, gated by a count-enable level. A program-request strobe writes the present code back to the memory and waits until the memory reports completion. Until that first load finishes, the output stays at a reset code and the block takes no commands.

The memory port works on a request and busy handshake. A one-cycle read or write request is registered by the memory, which raises `nv_busy` on the following cycle. The memory holds `nv_busy` until the operation is done; a write may keep it high for as long as 100 ms. Read data is taken in the first cycle in which `nv_busy` is low again. The code held in a fresh memory is mid-scale, 0x40.

Top module: `trim_nv_ctrl`

## Requirements
- R1: While reset is asserted and until the power-on read completes, `dac_code` equals `RESET_CODE` (default 0) and `busy` is 1. After reset release exactly one one-cycle `nv_rd_req` pulse is issued.
- R2: When the power-on read completes, `dac_code` takes the value on `nv_rd_data` and `busy` falls to 0.
- R3: An accepted increment at code 127 leaves the code at 127; there is no wrap.
- R4: An accepted decrement at code 0 leaves the code at 0; there is no wrap.
- R5: Each accepted strobe moves the code by exactly one step. If `inc_req` and `dec_req` are both high in the same cycle, the increment is taken.
- R6: While `cnt_en` is low, increment and decrement strobes leave `dac_code` unchanged.
- R7: Increments and decrements take effect only after `cnt_en` has been high for `EN_HOLD` consecutive cycles since the load completed. Any low cycle restarts this count.
- R8: A program request issues a one-cycle `nv_wr_req` with `nv_wr_data` equal to `dac_code`, whatever the level of `cnt_en`.
- R9: From a program request until `nv_busy` falls, `busy` is 1 and all strobes are ignored.
- R10: When a write completes, `wr_done` is high for exactly one cycle, in the first cycle in which `busy` is 0.
- R11: The first increment or decrement strobe after the power-on load, and the first one after each completed write, is discarded whatever the level of `cnt_en`.
- R12: A program request in the same cycle as an increment or decrement takes priority. The write is performed and the code does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_req | input | 1 | Step-up strobe |
| dec_req | input | 1 | Step-down strobe |
| prog_req | input | 1 | Store-to-memory strobe |
| cnt_en | input | 1 | Count-enable level |
| nv_rd_data | input | CODE_W | Read data from the memory |
| nv_busy | input | 1 | Memory operation in progress |
| nv_rd_req | output | 1 | One-cycle read request |
| nv_wr_req | output | 1 | One-cycle write request |
| nv_wr_data | output | CODE_W | Data to be written |
| dac_code | output | CODE_W | Present trim code to the DAC |
| busy | output | 1 | Load or write in progress |
| wr_done | output | 1 | One-cycle write-complete flag |

## Verification
The bench builds the block with `CODE_W` of 7 and `EN_HOLD` cut to 8 cycles. With the short hold, enable dropouts and the re-arm window can be exercised in a few cycles, instead of the 250,000 cycles of a 1 ms hold. The memory stub's write latency is set anew for each write, from zero up to about twenty cycles. This covers the busy window and the strobes injected during it. Resets with memory contents at 0x00, 0x40 and 0x7F start the code at either end of the range, so both saturation limits are reached directly.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic [2:0] {
    SEQ_BOOT,
    SEQ_RD_REQ,
    SEQ_RD_WAIT,
    SEQ_IDLE,
    SEQ_WR_REQ,
    SEQ_WR_WAIT
  } seq_state_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic prog;
  } trim_cmd_t;

endpackage

// File: rtl/trim_pulse_qual.sv
module trim_pulse_qual
  import trim_pkg::*;
#(
  parameter int EN_HOLD = 250000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle,
  input  logic      loaded,
  input  logic      arm_skip,
  input  logic      inc_req,
  input  logic      dec_req,
  input  logic      prog_req,
  input  logic      cnt_en,
  output trim_cmd_t cmd
);

  localparam int HOLD_W = $clog2(EN_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LIM = HOLD_W'(EN_HOLD);

  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              skip_q, skip_d;
  logic              pulse, en_ok, take;

  always_comb begin
    pulse = idle & ~prog_req & (inc_req | dec_req);
    en_ok = cnt_en & (hold_q == HOLD_LIM);
    take  = pulse & ~skip_q & en_ok;

    if (!loaded || !cnt_en)      hold_d = '0;
    else if (hold_q != HOLD_LIM) hold_d = hold_q + 1'b1;
    else                         hold_d = hold_q;

    if (arm_skip)   skip_d = 1'b1;
    else if (pulse) skip_d = 1'b0;
    else            skip_d = skip_q;

    cmd.prog = idle & prog_req;
    cmd.up   = take & inc_req;
    cmd.dn   = take & ~inc_req & dec_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      skip_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      skip_q <= skip_d;
    end
  end

  // R11: an armed skip absorbs the next pulse
  p_skip_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && pulse && !arm_skip) |=> !skip_q);

  // R7: an enable dropout restarts the hold window
  p_hold_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en) |=> (hold_q == '0));

endmodule

// File: rtl/trim_setting_reg.sv
module trim_setting_reg #(
  parameter int                CODE_W     = 7,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] load_val,
  input  logic              up,
  input  logic              dn,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  always_comb begin
    code_en = 1'b0;
    code_d  = code_q;
    if (load) begin
      code_en = 1'b1;
      code_d  = load_val;
    end else if (up && code_q != CODE_MAX) begin
      code_en = 1'b1;
      code_d  = code_q + 1'b1;
    end else if (dn && code_q != CODE_MIN) begin
      code_en = 1'b1;
      code_d  = code_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= RESET_CODE;
    else if (code_en) code_q <= code_d;
  end

  assign code = code_q;

  p_sat_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CODE_MAX && up && !load) |=> (code_q == CODE_MAX));

  p_sat_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CODE_MIN && dn && !load) |=> (code_q == CODE_MIN));

  p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1
                 || code_q == $past(code_q) - 1'b1));

endmodule

// File: rtl/trim_nv_seq.sv
module trim_nv_seq
  import trim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prog_go,
  input  logic nv_busy,
  output logic nv_rd_req,
  output logic nv_wr_req,
  output logic load,
  output logic loaded,
  output logic busy,
  output logic arm_skip,
  output logic wr_done
);

  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_BOOT:    state_d = SEQ_RD_REQ;
      SEQ_RD_REQ:  state_d = SEQ_RD_WAIT;
      SEQ_RD_WAIT: if (!nv_busy) state_d = SEQ_IDLE;
      SEQ_IDLE:    if (prog_go)  state_d = SEQ_WR_REQ;
      SEQ_WR_REQ:  state_d = SEQ_WR_WAIT;
      SEQ_WR_WAIT: if (!nv_busy) state_d = SEQ_IDLE;
      default:     state_d = SEQ_BOOT;
    endcase
    load     = (state_q == SEQ_RD_WAIT) && !nv_busy;
    done_d   = (state_q == SEQ_WR_WAIT) && !nv_busy;
    arm_skip = load | done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_BOOT;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign nv_rd_req = (state_q == SEQ_RD_REQ);
  assign nv_wr_req = (state_q == SEQ_WR_REQ);
  assign busy      = (state_q != SEQ_IDLE);
  assign loaded    = (state_q == SEQ_IDLE) || (state_q == SEQ_WR_REQ)
                     || (state_q == SEQ_WR_WAIT);
  assign wr_done   = done_q;

  p_rd_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    nv_rd_req |=> !nv_rd_req);

  p_wr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_req |=> !nv_wr_req);

  p_wait_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WR_WAIT && nv_busy) |=> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> !busy);

endmodule

// File: rtl/trim_nv_ctrl.sv
module trim_nv_ctrl
  import trim_pkg::*;
#(
  parameter int                CODE_W     = 7,
  parameter logic [CODE_W-1:0] RESET_CODE = '0,
  parameter int                EN_HOLD    = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_req,
  input  logic              dec_req,
  input  logic              prog_req,
  input  logic              cnt_en,
  input  logic [CODE_W-1:0] nv_rd_data,
  input  logic              nv_busy,
  output logic              nv_rd_req,
  output logic              nv_wr_req,
  output logic [CODE_W-1:0] nv_wr_data,
  output logic [CODE_W-1:0] dac_code,
  output logic              busy,
  output logic              wr_done
);

  logic      rst_meta_q, rst_sync_n;
  logic      load, loaded, arm_skip;
  trim_cmd_t cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  trim_nv_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .prog_go  (cmd.prog),
    .nv_busy  (nv_busy),
    .nv_rd_req(nv_rd_req),
    .nv_wr_req(nv_wr_req),
    .load     (load),
    .loaded   (loaded),
    .busy     (busy),
    .arm_skip (arm_skip),
    .wr_done  (wr_done)
  );

  trim_pulse_qual #(.EN_HOLD(EN_HOLD)) u_qual (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .idle    (!busy),
    .loaded  (loaded),
    .arm_skip(arm_skip),
    .inc_req (inc_req),
    .dec_req (dec_req),
    .prog_req(prog_req),
    .cnt_en  (cnt_en),
    .cmd     (cmd)
  );

  trim_setting_reg #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_code (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load),
    .load_val(nv_rd_data),
    .up      (cmd.up),
    .dn      (cmd.dn),
    .code    (dac_code)
  );

  assign nv_wr_data = dac_code;

  p_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cnt_en && !load) |=> $stable(dac_code));

  p_busy_freeze_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && loaded) |=> $stable(dac_code));

  p_prog_first_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && prog_req) |=> (busy && $stable(dac_code)));

  p_preload_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!loaded && !load) |=> (dac_code == RESET_CODE));

endmodule

// File: tb/trim_nv_ctrl_tb_top.sv
`timescale 1ns/1ps
module trim_nv_ctrl_tb_top;

  localparam int CW      = 7;
  localparam int HOLD    = 8;
  localparam int RD_LAT  = 3;
  localparam int MAXC    = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          inc_req, dec_req, prog_req, cnt_en;
  logic [CW-1:0] nv_rd_data, nv_wr_data, dac_code;
  logic          nv_busy, nv_rd_req, nv_wr_req, busy, wr_done;

  int            checks = 0;
  int            errors = 0;
  bit            finished = 0;

  logic [CW-1:0] mem_q;
  int            lat_q, wr_lat_v;
  int            rd_pulses, wr_pulses;

  int            m_code;
  bit            m_skip, m_ready;

  always #2 clk = ~clk;

  trim_nv_ctrl #(.CODE_W(CW), .RESET_CODE('0), .EN_HOLD(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .inc_req(inc_req), .dec_req(dec_req),
    .prog_req(prog_req), .cnt_en(cnt_en), .nv_rd_data(nv_rd_data),
    .nv_busy(nv_busy), .nv_rd_req(nv_rd_req), .nv_wr_req(nv_wr_req),
    .nv_wr_data(nv_wr_data), .dac_code(dac_code), .busy(busy),
    .wr_done(wr_done)
  );

  // memory stub: registers requests, busy for latency+1 cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_busy <= 1'b0;
      lat_q   <= 0;
    end else if (nv_rd_req) begin
      nv_busy   <= 1'b1;
      lat_q     <= RD_LAT;
      rd_pulses <= rd_pulses + 1;
    end else if (nv_wr_req) begin
      nv_busy   <= 1'b1;
      lat_q     <= wr_lat_v;
      mem_q     <= nv_wr_data;
      wr_pulses <= wr_pulses + 1;
    end else if (nv_busy) begin
      if (lat_q == 0) nv_busy <= 1'b0;
      else            lat_q   <= lat_q - 1;
    end
  end
  assign nv_rd_data = mem_q;

  function automatic int step_model(int c, bit up, bit dn);
    if (up)      return (c == MAXC) ? c : c + 1;
    else if (dn) return (c == 0) ? c : c - 1;
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 5000) begin tick(); n++; end
    chk(req, busy, 0);
  endtask

  task automatic do_reset(logic [CW-1:0] init);
    @(negedge clk);
    rst_n = 1'b0; mem_q = init; rd_pulses = 0; wr_pulses = 0;
    inc_req = 0; dec_req = 0; prog_req = 0;
    repeat (3) tick();
    chk("R1 reset code", dac_code, 0);
    chk("R1 busy in reset", busy, 1);
    rst_n = 1'b1;
    tick();
    chk("R1 held before load", dac_code, 0);
    wait_idle("R2 load done");
    chk("R2 loaded code", dac_code, init);
    chk("R1 one read", rd_pulses, 1);
    m_code = init; m_skip = 1; m_ready = 0;
  endtask

  task automatic en_settle();
    cnt_en = 1'b1;
    repeat (HOLD + 2) tick();
    m_ready = 1;
  endtask

  // inc/dec strobe; check after the capturing edge
  task automatic step(bit up, bit dn, string req);
    inc_req = up; dec_req = dn;
    tick();
    inc_req = 0; dec_req = 0;
    if (up || dn) begin
      if (m_skip) m_skip = 0;
      else if (cnt_en && m_ready) m_code = step_model(m_code, up, dn);
    end
    chk(req, dac_code, m_code);
  endtask

  task automatic prog(int lat, bit up, bit dn, bit inject, string req);
    wr_lat_v = lat;
    prog_req = 1; inc_req = up; dec_req = dn;
    tick();
    prog_req = 0; inc_req = 0; dec_req = 0;
    chk({req, " busy"}, busy, 1);
    if (inject) begin
      inc_req = 1; tick(); inc_req = 0;
      chk("R9 strobe while busy", dac_code, m_code);
    end
    wait_idle(req);
    chk("R8 stored value", mem_q, m_code);
    chk("R10 done high", wr_done, 1);
    chk("R12 code unchanged", dac_code, m_code);
    tick();
    chk("R10 done one cycle", wr_done, 0);
    m_skip = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pw;
    cnt_en = 0; wr_lat_v = 2; rd_pulses = 0; wr_pulses = 0;
    rst_n = 1'b0; inc_req = 0; dec_req = 0; prog_req = 0; mem_q = 7'h40;
    void'($urandom(32'h5eed_0042));

    do_reset(7'h40);
    en_settle();
    step(1, 0, "R11 first pulse discarded");
    step(1, 0, "R5 increment");
    step(0, 1, "R5 decrement");
    step(1, 1, "R5 increment wins");
    cnt_en = 0; m_ready = 0;
    step(1, 0, "R6 disabled inc");
    step(0, 1, "R6 disabled dec");
    cnt_en = 1;
    step(1, 0, "R7 before hold elapsed");
    en_settle();
    step(1, 0, "R7 after hold");
    cnt_en = 0; m_ready = 0;
    pw = wr_pulses;
    prog(5, 0, 0, 1, "R8 program with enable low");
    chk("R8 one write", wr_pulses - pw, 1);
    en_settle();
    step(0, 1, "R11 pulse after write discarded");
    step(0, 1, "R5 decrement after rearm");
    prog(0, 1, 0, 0, "R12 program over increment");
    step(1, 0, "R11 discard again");

    do_reset(7'h7F);
    en_settle();
    step(1, 0, "R11 discard");
    step(1, 0, "R3 saturate high");
    step(1, 0, "R3 saturate high again");
    do_reset(7'h00);
    en_settle();
    step(0, 1, "R11 discard");
    step(0, 1, "R4 saturate low");

    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 100;
      if (r < 5) begin
        prog($urandom % 21, 0, 0, ($urandom % 2) == 1, "R8 random program");
      end else if (r < 12) begin
        cnt_en = 0; m_ready = 0;
        step(($urandom % 2) == 1, 1, "R6 random disabled");
      end else begin
        if (!m_ready) en_settle();
        case ($urandom % 3)
          0: step(1, 0, "R5 random inc");
          1: step(0, 1, "R5 random dec");
          default: step(1, 1, "R5 random both");
        endcase
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule